// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two signed two's-complement numbers of `W` bits (16 by default) with one add/subtract unit reused over `W` clock cycles, trading latency for area. A one-cycle `start_i` loads the multiplier into the low half of a shift register and clears the accumulator. After that, each clock consumes one multiplier bit, and a one-cycle `done_o` marks the moment the `2W`-bit product is valid.

Signed operands need no recoding. When the multiplier is negative, the block runs in negated mode. The multiplier is negated bit by bit as it leaves the register, using a single carry flip-flop. The shared unit subtracts the multiplicand instead of adding it. Negating both operands leaves the product unchanged. The multiplicand is not captured: the caller keeps `mcand_i` constant from the start cycle until `done_o`. The accumulator carries one bit above the operand width, so that products involving the most negative value keep their sign.

Top module: `shiftadd_smul`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `done_o` = 0 and `product_o` = 0.
- R2: For a non-negative multiplier, `product_o` equals the signed product `mcand_i * mplier_i` as a `2W`-bit two's-complement value when `done_o` is high.
- R3: For a negative multiplier (bit `W-1` = 1), `product_o` equals the signed product when `done_o` is high.
- R4: The extreme pairs give exact results: `-2^(W-1) * -2^(W-1) = 2^(2W-2)`, `-2^(W-1) * -1 = 2^(W-1)`, and `(2^(W-1)-1) * -2^(W-1)`.
- R5: `done_o` is high in the cycle that follows the `W`-th rising edge after the edge that accepted `start_i`.
- R6: `done_o` stays high for exactly one cycle.
- R7: A `start_i` raised while an operation is running is ignored. The running product is unaffected.
- R8: Once `done_o` has been raised, `product_o` holds its value until the next accepted start.
- R9: A `start_i` presented in the cycle where `done_o` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a multiply. Accepted only when idle |
| mcand_i | input | W | Signed multiplicand. Held constant for the whole operation |
| mplier_i | input | W | Signed multiplier. Sampled on the accepted start |
| done_o | output | 1 | One-cycle pulse: the product is valid |
| product_o | output | 2W | Signed product |

## Verification
If the edge that accepts a start is counted as edge zero, the product and `done_o` are due just after edge `W`. The bench drives inputs on falling edges and counts falling edges from the one that drops `start_i`. It expects to see `done_o` after exactly `W` of them, and it compares the product in that same half-cycle. The idle checks take place one and more falling edges later, where `done_o` must already be low and the product unchanged. A second instance with `W` = 4 is swept over all 256 operand pairs with the same timing.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } addsub_e;

    typedef struct packed {
        logic carry;
        logic bit_out;
    } neg_step_t;

    // One step of a running two's-complement negation: invert, add carry.
    function automatic neg_step_t neg_step(input logic b, input logic c);
        neg_step_t r;
        r.bit_out = (~b) ^ c;
        r.carry   = (~b) & c;
        return r;
    endfunction

endpackage

// File: rtl/smul_sequencer.sv
module smul_sequencer #(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic             last;

    assign load_o = start_i && !busy_q;
    assign step_o = busy_q;
    assign last   = busy_q && (cnt_q == LAST);
    assign busy_o = busy_q;
    assign done_o = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                cnt_q  <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/smul_serial_negator.sv
module smul_serial_negator
    import smul_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load_i,
    input  logic    sign_i,
    input  logic    step_i,
    input  logic    bit_i,
    output logic    bit_o,
    output addsub_e op_o
);
    logic      neg_q;
    logic      carry_q;
    neg_step_t nx;

    assign nx    = neg_step(bit_i, carry_q);
    assign bit_o = neg_q ? nx.bit_out : bit_i;
    assign op_o  = neg_q ? OP_SUB : OP_ADD;

    always_ff @(posedge clk) begin
        if (rst) begin
            neg_q   <= 1'b0;
            carry_q <= 1'b1;
        end else if (load_i) begin
            neg_q   <= sign_i;
            carry_q <= 1'b1;
        end else if (step_i && neg_q) begin
            carry_q <= nx.carry;
        end
    end
endmodule

// File: rtl/smul_addsub.sv
module smul_addsub
    import smul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W:0]   acc_i,
    input  logic [W-1:0] mcand_i,
    input  logic         en_i,
    input  addsub_e      op_i,
    output logic [W:0]   sum_o
);
    logic [W:0] ext;
    logic [W:0] operand;
    logic       cin;

    always_comb begin
        ext = {mcand_i[W-1], mcand_i};
        if (!en_i) begin
            operand = '0;
            cin     = 1'b0;
        end else if (op_i == OP_SUB) begin
            operand = ~ext;
            cin     = 1'b1;
        end else begin
            operand = ext;
            cin     = 1'b0;
        end
        sum_o = acc_i + operand + {{W{1'b0}}, cin};
    end
endmodule

// File: rtl/shiftadd_smul.sv
module shiftadd_smul
    import smul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic           done_o,
    output logic [2*W-1:0] product_o
);
    localparam int ACC_W = W + 1;

    logic             load;
    logic             step;
    logic             busy;
    logic             eff_bit;
    addsub_e          op;
    logic [ACC_W-1:0] acc_q;
    logic [W-1:0]     low_q;
    logic [ACC_W-1:0] sum;

    smul_sequencer #(.W(W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy),
        .done_o  (done_o)
    );

    smul_serial_negator u_neg (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .sign_i (mplier_i[W-1]),
        .step_i (step),
        .bit_i  (low_q[0]),
        .bit_o  (eff_bit),
        .op_o   (op)
    );

    smul_addsub #(.W(W)) u_alu (
        .acc_i   (acc_q),
        .mcand_i (mcand_i),
        .en_i    (eff_bit),
        .op_i    (op),
        .sum_o   (sum)
    );

    // Arithmetic right shift of {sum, low}: sign of the wide sum fills the top.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            low_q <= '0;
        end else if (load) begin
            acc_q <= '0;
            low_q <= mplier_i;
        end else if (step) begin
            acc_q <= {sum[ACC_W-1], sum[ACC_W-1:1]};
            low_q <= {sum[0], low_q[W-1:1]};
        end
    end

    assign product_o = {acc_q[W-1:0], low_q};
endmodule

// File: rtl/smul_checker.sv
module smul_checker #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           start_i,
    input logic           busy_i,
    input logic           done_i,
    input logic [2*W-1:0] product_i
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) run_cnt <= '0;
        else if (start_i && !busy_i) run_cnt <= '0;
        else if (busy_i) run_cnt <= run_cnt + 1'b1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!done_i && product_i == '0));

    // R5
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done_i |-> (run_cnt == CW'(W)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_i |=> !done_i);

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && run_cnt < CW'(W - 1)) |=> busy_i);

    // R8
    product_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_i && !start_i) |=> $stable(product_i));
endmodule

bind shiftadd_smul smul_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .busy_i    (busy),
    .done_i    (done_o),
    .product_i (product_o)
);

// File: tb/shiftadd_smul_tb.sv
module shiftadd_smul_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic        start = 1'b0;
    logic [15:0] a = '0, b = '0;
    logic        done;
    logic [31:0] prod;

    logic        s_start = 1'b0;
    logic [3:0]  s_a = '0, s_b = '0;
    logic        s_done;
    logic [7:0]  s_prod;

    shiftadd_smul #(.W(16)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .mcand_i(a), .mplier_i(b),
        .done_o(done), .product_o(prod));

    shiftadd_smul #(.W(4)) u_dut_small (
        .clk(clk), .rst(rst), .start_i(s_start), .mcand_i(s_a), .mplier_i(s_b),
        .done_o(s_done), .product_o(s_prod));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge where done is seen.
    task automatic op16(input logic [15:0] x, input logic [15:0] y, input string req, input bit poke);
        logic signed [31:0] exp;
        int k;
        exp = $signed(x) * $signed(y);
        a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 100) begin
            if (poke && k == 3) begin start = 1'b1; b = ~y; end
            else if (poke && k == 4) begin start = 1'b0; b = y; end
            @(negedge clk);
            k++;
        end
        check(k == 16, "R5", k, 16);
        check(prod == exp, req, $signed(prod), exp);
    endtask

    task automatic op4(input logic [3:0] x, input logic [3:0] y, input string req);
        logic signed [7:0] exp;
        int k;
        exp = $signed(x) * $signed(y);
        s_a = x; s_b = y; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        k = 0;
        while (!s_done && k < 50) begin
            @(negedge clk);
            k++;
        end
        check(k == 4, "R5", k, 4);
        check(s_prod == exp, req, $signed(s_prod), exp);
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R1
        check(done == 1'b0 && prod == '0, "R1", prod, 0);
        check(s_done == 1'b0 && s_prod == '0, "R1", s_prod, 0);
        rst = 1'b0;
        @(negedge clk);

        op16(16'd3, 16'd5, "R2", 1'b0);
        op16(16'hFFF3, 16'd1234, "R2", 1'b0);
        op16(16'd0, 16'h8000, "R3", 1'b0);
        op16(16'd77, 16'hFFFC, "R3", 1'b0);
        // R4 extremes
        op16(16'h8000, 16'h8000, "R4", 1'b0);
        op16(16'h8000, 16'hFFFF, "R4", 1'b0);
        op16(16'h7FFF, 16'h8000, "R4", 1'b0);
        op16(16'h8000, 16'h7FFF, "R4", 1'b0);
        // R7: restart attempt mid-run must be ignored
        op16(16'd1000, 16'hFF38, "R7", 1'b1);
        held = prod;
        // R6 / R8
        @(negedge clk);
        check(done == 1'b0, "R6", done, 0);
        check(prod == held, "R8", prod, held);
        repeat (5) @(negedge clk);
        check(prod == held, "R8", prod, held);
        // R9: back to back, second start issued in the done cycle
        op16(16'd21, 16'd2, "R9", 1'b0);
        op16(16'hFFFE, 16'hFFF9, "R9", 1'b0);
        @(negedge clk);
        for (int i = 0; i < 60; i++) begin
            logic [15:0] x, y;
            x = 16'($urandom);
            y = 16'($urandom);
            op16(x, y, y[15] ? "R3" : "R2", 1'b0);
        end
        @(negedge clk);
        // Exhaustive sweep of the 4-bit instance
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                string req;
                if ((i == 8 && (j == 8 || j == 15)) || (i == 7 && j == 8)) req = "R4";
                else if (j >= 8) req = "R3";
                else req = "R2";
                op4(4'(i), 4'(j), req);
            end
        end
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule